// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches one demodulated infrared receiver line. It samples the line once every `CLK_DIV` clocks and can invert it first. Each stretch of constant level becomes one byte, or several bytes for a long stretch. A byte holds the level in its top bit and the stretch length, in samples minus one, in its low seven bits. Brief level flips no longer than a programmable noise limit are treated as noise and merged into the surrounding run.

A packet begins at the first pulse sample. It closes once the line has stayed at space for more than a programmable idle limit. At that point the trailing space run is written out, a packet-end flag is raised, and the block writes nothing more until the next pulse sample. Bytes collect in a FIFO that software drains through a data register. A status register reports the fill level, an overflow flag and the packet-end flag. The two flags are cleared by writing 1. A single interrupt line combines the enabled status flags with a "fill level above threshold" condition.

Top module: `irrx_top`

## Requirements
- R1: The line is sampled exactly once every `CLK_DIV` clocks while the block is enabled. A level held for N·`CLK_DIV` clocks therefore counts as N samples.
- R2: Capture runs only when register 0x00 has bit 0 = 1, bit 1 = 1 and bits 5:4 = 2'b11. With any other setting no byte is written and the capture state is cleared.
- R3: Bit 2 of register 0x10 inverts the line before sampling. Level 1 after any inversion is a pulse.
- R4: A byte has the level in bit 7 (1 = pulse) and the run length minus one in bits 6:0.
- R5: An opposite-level stretch of at most T samples is merged into the current run and starts no new byte. T is bits 7:2 of register 0x34. A stretch of T+1 samples ends the run.
- R6: A run longer than 128 samples is written as 128-sample bytes (code 0x7F) followed by a byte for the rest.
- R7: A packet starts at the first pulse sample. When more than I consecutive space samples are seen (I = bits 15:8 of register 0x34), the space run is written, status bit 1 is set, and nothing more is written until a pulse sample arrives.
- R8: Reading register 0x20 pops the oldest byte. Reading it while the FIFO is empty returns 0. Status bits starting at bit 8 hold the fill count.
- R9: A byte that arrives while the FIFO is full is dropped and status bit 0 is set.
- R10: Writing 1 to status bit 0 or bit 1 clears that bit, and writing 0 leaves it unchanged. Status bit 4 is live: it is 1 while the fill count exceeds bits 13:8 of register 0x2C.
- R11: `irq` is high while any status bit 0, 1 or 4 is set together with the enable bit in the same position of register 0x2C.
- R12: After reset all registers read 0, the FIFO is empty and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_in | input | 1 | Demodulated receiver line (asynchronous) |
| reg_addr | input | 6 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; data is valid on the next clock |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest states to reach from the ports are the ones where two output rules meet in a single packet. One is a trailing space that is longer than 128 samples, so it is split before the idle flush. The other is a FIFO that fills up partway through a packet, so the flush byte itself is dropped. The bench reaches them by holding the line at each level for an exact multiple of the sample divisor, which makes every run length known in whole samples. It programs a large idle limit to get the split case. It sends a train of one-sample pulses, with the noise limit at zero, to push more bytes than the FIFO depth into the FIFO.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  localparam logic [5:0] A_CTL   = 6'h00;
  localparam logic [5:0] A_RXCFG = 6'h10;
  localparam logic [5:0] A_DATA  = 6'h20;
  localparam logic [5:0] A_IEN   = 6'h2C;
  localparam logic [5:0] A_STAT  = 6'h30;
  localparam logic [5:0] A_SCFG  = 6'h34;

  localparam int RUN_W    = 9;
  localparam int CHUNK    = 128;
  localparam int NTHR_W   = 6;
  localparam int ITHR_W   = 8;
  localparam int TRIG_W   = 6;

  // Build one FIFO byte from a level and a sample count (1..128).
  function automatic logic [7:0] pack_run(input logic lvl, input logic [RUN_W-1:0] nsamp);
    return {lvl, 7'(nsamp - RUN_W'(1))};
  endfunction

  // Saturating increment for the idle counter.
  function automatic logic [RUN_W-1:0] sat_inc(input logic [RUN_W-1:0] v);
    return (&v) ? v : v + RUN_W'(1);
  endfunction
endpackage

// File: rtl/irrx_sampler.sv
module irrx_sampler #(
  parameter int CLK_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ir_in,
  input  logic invert,
  output logic smp_valid,
  output logic smp_lvl
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] div_q;
  logic [1:0]    sync_q;
  logic          tick;

  assign tick = (div_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      sync_q    <= '0;
      smp_valid <= 1'b0;
      smp_lvl   <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], ir_in};
      smp_valid <= en & tick;
      if (!en || tick) div_q <= '0;
      else             div_q <= div_q + DW'(1);
      if (en && tick)  smp_lvl <= sync_q[1] ^ invert;
    end
  end

  initial begin
    a_div_min: assert (CLK_DIV >= 4);
  end

  p_sample_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  p_off_no_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !smp_valid);
endmodule

// File: rtl/irrx_runner.sv
module irrx_runner
  import irrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              smp_valid,
  input  logic              smp_lvl,
  input  logic [NTHR_W-1:0] nthr,
  input  logic [ITHR_W-1:0] ithr,
  output logic              emit,
  output logic [7:0]        emit_byte,
  output logic              pkt_end
);
  logic             active_q, active_d;
  logic             cur_q, cur_d;
  logic             flush_q, flush_d;
  logic [RUN_W-1:0] run_q, run_d, idle_q, idle_d, sum, pend_ext;
  logic [NTHR_W:0]  pend_q, pend_d;

  assign pend_ext = RUN_W'(pend_q);
  assign sum      = run_q + pend_ext + RUN_W'(1);

  always_comb begin
    active_d  = active_q;
    cur_d     = cur_q;
    run_d     = run_q;
    idle_d    = idle_q;
    pend_d    = pend_q;
    flush_d   = 1'b0;
    emit      = 1'b0;
    emit_byte = 8'h00;
    pkt_end   = 1'b0;
    if (flush_q) begin
      emit      = 1'b1;
      emit_byte = pack_run(1'b0, run_q);
      pkt_end   = 1'b1;
    end else if (smp_valid) begin
      if (!active_q) begin
        if (smp_lvl) begin
          active_d = 1'b1;
          cur_d    = 1'b1;
          run_d    = RUN_W'(1);
          pend_d   = '0;
          idle_d   = '0;
        end
      end else begin
        idle_d = smp_lvl ? '0 : sat_inc(idle_q);
        if (smp_lvl == cur_q) begin
          pend_d = '0;
          if (sum > RUN_W'(CHUNK)) begin
            emit      = 1'b1;
            emit_byte = pack_run(cur_q, RUN_W'(CHUNK));
            run_d     = sum - RUN_W'(CHUNK);
          end else begin
            run_d = sum;
          end
        end else if (pend_ext + RUN_W'(1) > RUN_W'(nthr)) begin
          emit      = 1'b1;
          emit_byte = pack_run(cur_q, run_q);
          cur_d     = smp_lvl;
          run_d     = pend_ext + RUN_W'(1);
          pend_d    = '0;
        end else begin
          pend_d = pend_q + (NTHR_W+1)'(1);
        end
        if (!cur_d && idle_d > RUN_W'(ithr)) begin
          flush_d  = 1'b1;
          active_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cur_q    <= 1'b0;
      flush_q  <= 1'b0;
      run_q    <= '0;
      idle_q   <= '0;
      pend_q   <= '0;
    end else if (!en) begin
      active_q <= 1'b0;
      cur_q    <= 1'b0;
      flush_q  <= 1'b0;
      run_q    <= '0;
      idle_q   <= '0;
      pend_q   <= '0;
    end else begin
      active_q <= active_d;
      cur_q    <= cur_d;
      flush_q  <= flush_d;
      run_q    <= run_d;
      idle_q   <= idle_d;
      pend_q   <= pend_d;
    end
  end

  // A run in progress always holds between 1 and 128 samples.
  p_run_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (run_q >= RUN_W'(1) && run_q <= RUN_W'(CHUNK)));
  // A packet opens only on a pulse sample.
  p_start_on_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(smp_valid && smp_lvl));
  // After packet end nothing is written until a new packet opens.
  p_quiet_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !emit);
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [7:0]                 din,
  input  logic                       pop,
  output logic [7:0]                 dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> count == $past(count));
  p_pop_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> count == $past(count) - (AW+1)'(1));
endmodule

// File: rtl/irrx_top.sv
module irrx_top
  import irrx_pkg::*;
#(
  parameter int CLK_DIV    = 64,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic              gen_q, rxen_q;
  logic [1:0]        mode_q;
  logic              inv_q;
  logic [NTHR_W-1:0] nthr_q;
  logic [ITHR_W-1:0] ithr_q;
  logic              ie_ovf_q, ie_pkt_q, ie_avl_q;
  logic [TRIG_W-1:0] trig_q;
  logic              st_ovf_q, st_pkt_q;

  logic              cap_en, smp_valid, smp_lvl;
  logic              emit, pkt_end, fifo_full, fifo_empty, pop, avail;
  logic [7:0]        emit_byte, fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [31:0]       stat_w;
  logic              wr_ctl, wr_rxcfg, wr_ien, wr_scfg, wr_stat;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata[31:16];

  assign cap_en   = gen_q & rxen_q & (mode_q == 2'b11);
  assign wr_ctl   = reg_wr && reg_addr == A_CTL;
  assign wr_rxcfg = reg_wr && reg_addr == A_RXCFG;
  assign wr_ien   = reg_wr && reg_addr == A_IEN;
  assign wr_scfg  = reg_wr && reg_addr == A_SCFG;
  assign wr_stat  = reg_wr && reg_addr == A_STAT;
  assign pop      = reg_rd && reg_addr == A_DATA;
  assign avail    = 32'(fifo_cnt) > 32'(trig_q);

  irrx_sampler #(.CLK_DIV(CLK_DIV)) u_smp (
    .clk(clk), .rst_n(rst_n), .en(cap_en), .ir_in(ir_in), .invert(inv_q),
    .smp_valid(smp_valid), .smp_lvl(smp_lvl)
  );

  irrx_runner u_run (
    .clk(clk), .rst_n(rst_n), .en(cap_en), .smp_valid(smp_valid), .smp_lvl(smp_lvl),
    .nthr(nthr_q), .ithr(ithr_q), .emit(emit), .emit_byte(emit_byte), .pkt_end(pkt_end)
  );

  irrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(emit), .din(emit_byte), .pop(pop),
    .dout(fifo_dout), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q    <= 1'b0;
      rxen_q   <= 1'b0;
      mode_q   <= 2'b00;
      inv_q    <= 1'b0;
      nthr_q   <= '0;
      ithr_q   <= '0;
      ie_ovf_q <= 1'b0;
      ie_pkt_q <= 1'b0;
      ie_avl_q <= 1'b0;
      trig_q   <= '0;
      st_ovf_q <= 1'b0;
      st_pkt_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        gen_q  <= reg_wdata[0];
        rxen_q <= reg_wdata[1];
        mode_q <= reg_wdata[5:4];
      end
      if (wr_rxcfg) inv_q <= reg_wdata[2];
      if (wr_ien) begin
        ie_ovf_q <= reg_wdata[0];
        ie_pkt_q <= reg_wdata[1];
        ie_avl_q <= reg_wdata[4];
        trig_q   <= reg_wdata[8 +: TRIG_W];
      end
      if (wr_scfg) begin
        nthr_q <= reg_wdata[2 +: NTHR_W];
        ithr_q <= reg_wdata[8 +: ITHR_W];
      end
      // New events win over a clear in the same cycle.
      st_ovf_q <= (emit && fifo_full) | (st_ovf_q & ~(wr_stat & reg_wdata[0]));
      st_pkt_q <= pkt_end | (st_pkt_q & ~(wr_stat & reg_wdata[1]));
    end
  end

  always_comb begin
    stat_w             = '0;
    stat_w[0]          = st_ovf_q;
    stat_w[1]          = st_pkt_q;
    stat_w[4]          = avail;
    stat_w[8 +: CNT_W] = fifo_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTL:   reg_rdata <= {26'd0, mode_q, 2'b00, rxen_q, gen_q};
        A_RXCFG: reg_rdata <= {29'd0, inv_q, 2'b00};
        A_DATA:  reg_rdata <= fifo_empty ? 32'd0 : {24'd0, fifo_dout};
        A_IEN:   reg_rdata <= {18'd0, trig_q, 3'b000, ie_avl_q, 2'b00, ie_pkt_q, ie_ovf_q};
        A_STAT:  reg_rdata <= stat_w;
        A_SCFG:  reg_rdata <= {16'd0, ithr_q, nthr_q, 2'b00};
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign irq = (st_ovf_q & ie_ovf_q) | (st_pkt_q & ie_pkt_q) | (avail & ie_avl_q);

  p_overflow_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && fifo_full) |=> st_ovf_q);
  p_packet_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> st_pkt_q);
  p_disabled_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !$past(cap_en)) |-> !emit);
  p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_ovf_q && !ie_pkt_q && !ie_avl_q) |-> !irq);
endmodule

// File: tb/irrx_top_tb_top.sv
module irrx_top_tb_top;
  localparam int DIV   = 4;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irrx_top #(.CLK_DIV(DIV), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [5:0]  nthr;
    logic [7:0]  ithr;
    logic [7:0]  pa;
    logic [7:0]  gap;
    logic [7:0]  pb;
    logic [3:0]  nexp;
    logic [47:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{6'd1, 8'd20,  8'd10,  8'd5, 8'd7, 4'd4, 48'h89_04_86_14_00_00},
    '{6'd2, 8'd20,  8'd10,  8'd2, 8'd7, 4'd2, 48'h92_14_00_00_00_00},
    '{6'd2, 8'd20,  8'd10,  8'd3, 8'd7, 4'd4, 48'h89_02_86_14_00_00},
    '{6'd1, 8'd20,  8'd200, 8'd5, 8'd3, 4'd5, 48'hFF_C7_04_82_14_00},
    '{6'd0, 8'd20,  8'd1,   8'd1, 8'd1, 4'd4, 48'h80_00_80_14_00_00},
    '{6'd1, 8'd200, 8'd5,   8'd2, 8'd4, 4'd5, 48'h84_01_83_7F_48_00},
    '{6'd1, 8'd20,  8'd128, 8'd5, 8'd2, 4'd4, 48'hFF_04_81_14_00_00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic hold(input logic lvl, input int nsamp);
    ir_in = lvl;
    repeat (nsamp * DIV) @(negedge clk);
  endtask

  task automatic drain();
    logic [31:0] st, d;
    rd(6'h30, st);
    for (int k = 0; k < int'(st[15:8]); k++) rd(6'h20, d);
  endtask

  task automatic setup(input logic [5:0] nthr, input logic [7:0] ithr, input logic inv);
    wr(6'h00, 32'h0);
    wr(6'h10, {29'd0, inv, 2'b00});
    wr(6'h34, {16'd0, ithr, nthr, 2'b00});
    wr(6'h30, 32'hFF);
    ir_in = inv;
    repeat (4) @(negedge clk);
    wr(6'h00, 32'h33);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(6'h00, d); chk("R12 ctl reset", d, 32'h0);
    rd(6'h30, d); chk("R12 status reset", d, 32'h0);
    rd(6'h34, d); chk("R12 sample cfg reset", d, 32'h0);
    chk("R12 irq reset", {31'd0, irq}, 32'h0);

    // Table of packets: R1 R4 R5 R6 R7
    for (int v = 0; v < 7; v++) begin
      setup(VECS[v].nthr, VECS[v].ithr, 1'b0);
      hold(1'b0, 3);
      hold(1'b1, int'(VECS[v].pa));
      hold(1'b0, int'(VECS[v].gap));
      hold(1'b1, int'(VECS[v].pb));
      hold(1'b0, int'(VECS[v].ithr) + 12);
      rd(6'h30, st);
      chk($sformatf("R7 packet end vec %0d", v), {31'd0, st[1]}, 32'd1);
      chk($sformatf("R8 fill count vec %0d", v), {24'd0, st[15:8]}, {28'd0, VECS[v].nexp});
      for (int k = 0; k < int'(VECS[v].nexp); k++) begin
        rd(6'h20, d);
        chk($sformatf("R1 R4 R5 R6 byte %0d vec %0d", k, v), d,
            {24'd0, VECS[v].exp[47 - 8*k -: 8]});
      end
      drain();
    end

    // R3 inverted line: raw low is a pulse
    setup(6'd1, 8'd20, 1'b1);
    hold(1'b1, 3);
    hold(1'b0, 5);
    hold(1'b1, 32);
    rd(6'h30, st); chk("R3 count", {24'd0, st[15:8]}, 32'd2);
    rd(6'h20, d);  chk("R3 pulse byte", d, 32'h84);
    rd(6'h20, d);  chk("R3 space byte", d, 32'h14);
    drain();

    // R2 wrong mode, then missing receive enable
    wr(6'h10, 32'h0);
    wr(6'h30, 32'hFF);
    wr(6'h00, 32'h03);
    hold(1'b0, 2); hold(1'b1, 6); hold(1'b0, 30);
    rd(6'h30, st); chk("R2 mode 00 writes nothing", st, 32'h0);
    wr(6'h00, 32'h31);
    hold(1'b1, 6); hold(1'b0, 30);
    rd(6'h30, st); chk("R2 no rx enable writes nothing", st, 32'h0);

    // R9 overflow: 20 bytes into 16 entries
    setup(6'd0, 8'd20, 1'b0);
    hold(1'b0, 2);
    for (int p = 0; p < 10; p++) begin
      hold(1'b1, 1);
      hold(1'b0, 1);
    end
    hold(1'b0, 30);
    rd(6'h30, st); chk("R9 R10 status after overflow", st, 32'h1013);
    chk("R11 irq masked", {31'd0, irq}, 32'd0);
    wr(6'h2C, 32'h01);
    @(negedge clk); chk("R11 irq on overflow", {31'd0, irq}, 32'd1);
    wr(6'h30, 32'h01);
    rd(6'h30, st); chk("R10 clear overflow only", st, 32'h1012);
    chk("R11 irq drops after clear", {31'd0, irq}, 32'd0);
    wr(6'h2C, 32'h02);
    @(negedge clk); chk("R11 irq on packet end", {31'd0, irq}, 32'd1);
    wr(6'h30, 32'hFF);
    rd(6'h30, st); chk("R10 clear all keeps live level bit", st, 32'h1010);
    chk("R11 irq off after clear all", {31'd0, irq}, 32'd0);

    // R10 R11 fill threshold 7, R8 order
    wr(6'h2C, 32'h0710);
    @(negedge clk); chk("R11 irq on level", {31'd0, irq}, 32'd1);
    for (int k = 0; k < 8; k++) begin
      rd(6'h20, d);
      chk($sformatf("R8 fifo order %0d", k), d, (k % 2 == 0) ? 32'h80 : 32'h00);
    end
    chk("R10 count 8 above level", {31'd0, irq}, 32'd1);
    rd(6'h20, d);
    rd(6'h30, st); chk("R10 count 7 not above level", st, 32'h0700);
    chk("R11 irq low at level", {31'd0, irq}, 32'd0);
    for (int k = 0; k < 7; k++) rd(6'h20, d);
    chk("R8 last stored byte", d, 32'h00);
    rd(6'h20, d); chk("R8 empty read returns zero", d, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule